// File: doc/BRIEF.md
# Two-Stage Sequence Overvoltage Protection

This block guards one symmetrical-component voltage against overvoltage. It takes a magnitude word that upstream logic has already computed for the positive-, negative- or zero-sequence system. A strobe marks each new sample. The block compares that word against two graded settings: a sensitive low stage and a fast high stage. Each stage has its own pickup level. Each also has a release level, which is that pickup level scaled by a dropout ratio. Each stage also has its own trip delay, counted in sample strobes.

Every stage is a small state machine with three states. `ST_IDLE` means not picked up. `ST_TIMING` means picked up with the delay running. `ST_EXPIRED` means picked up with the delay elapsed. Its transitions are named as follows:
- *arm*: `ST_IDLE` to `ST_TIMING`, taken when a strobe sees the value at or above pickup.
- *arm-expire*: `ST_IDLE` to `ST_EXPIRED`, taken when the same happens with a delay of zero.
- *expire*: `ST_TIMING` to `ST_EXPIRED`, taken when the delay runs out.
- *release*: any picked-up state to `ST_IDLE`, taken when a strobe sees the value below the release level.
- *inhibit*: any state to `ST_IDLE`, taken on any clock while blocked.

A second machine forms the trip output, with the states `TR_CLEAR` and `TR_HELD`. Its *latch* transition is taken on a stage timeout. Its *unlatch* transition is taken when both stages are idle or a block is active.

Blocking comes from an external input in every variant. A variant select input decides which automatic sources are also honoured:
- A voltage-failure flag applies to the negative- and zero-sequence variants.
- A transformer-breaker flag applies to the same two variants.
- A single-pole reclose dead-time flag applies to the negative-sequence variant only.

Top module: `seqov_guard`

## Requirements
- R1: While `rst_n` is low and on the first clock after it rises, all five outputs are 0.
- R2: A stage picks up (its pickup output becomes 1 after the clock edge that samples the strobe) only on a clock with `tick`=1, not blocked, and `mag` >= that stage's pickup setting; one below pickup does not pick it up.
- R3: The release level is floor(pickup × ratio / 256), with ratio an 8-bit fraction. A picked-up stage stays picked up on a strobe with `mag` at or above the release level. It releases on a strobe with `mag` below it.
- R4: A stage that stays picked up raises its timeout output on the delay-th strobe after the strobe that picked it up. With a delay of 0, timeout rises together with pickup. Timeout is never 1 without pickup.
- R5: When a stage releases or is blocked, its timer clears to zero, and a later pickup runs the full delay again.
- R6: The low and high stages are independent: each uses only its own pickup, ratio and delay settings.
- R7: `trip` becomes 1 whenever either timeout is 1. It then stays 1 while at least one stage is still picked up, even after the timeouts clear. It is 0 once both stages are idle.
- R8: `ext_blk`=1 forces both stages idle and `trip` to 0 on the next clock, in every variant. While it is held, no pickup occurs.
- R9: With `variant` 1 (negative) or 2 (zero), `volt_fail`=1 or `vt_trip`=1 blocks like R8. With `variant` 0 (positive) or 3 (reserved), both flags are ignored.
- R10: `dead_time`=1 blocks like R8 only when `variant` is 1. It is ignored for `variant` 0 and 2.
- R11: On clocks without a strobe and without any active block, the pickup, timeout and trip outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sample strobe; `mag` is evaluated on clocks where it is 1 |
| mag | input | MAG_W | Sequence-voltage magnitude |
| variant | input | 2 | 0 positive, 1 negative, 2 zero, 3 reserved (acts as positive) |
| ext_blk | input | 1 | External block |
| volt_fail | input | 1 | Asymmetrical voltage-failure flag |
| vt_trip | input | 1 | Transformer-breaker trip flag |
| dead_time | input | 1 | Single-pole reclose dead-time flag |
| lo_pickup | input | MAG_W | Low-stage pickup level |
| lo_ratio | input | RATIO_W | Low-stage dropout ratio (fraction of 256) |
| lo_delay | input | DLY_W | Low-stage delay in strobes |
| hi_pickup | input | MAG_W | High-stage pickup level |
| hi_ratio | input | RATIO_W | High-stage dropout ratio (fraction of 256) |
| hi_delay | input | DLY_W | High-stage delay in strobes |
| lo_pu | output | 1 | Low stage picked up |
| lo_to | output | 1 | Low stage timed out |
| hi_pu | output | 1 | High stage picked up |
| hi_to | output | 1 | High stage timed out |
| trip | output | 1 | Combined trip |

## Verification
The bench probes one count below each pickup level. It also probes exactly the rounded-down release level and one count below it. A design that compared with the wrong inclusiveness, or rounded the release level up, would pick up or release one count too early. It counts the strobes to timeout, both after a fresh pickup and after a release and re-pickup. This catches an off-by-one delay and a timer that pauses instead of clearing, which would time out early. It also drops the high stage while the low stage stays up, to show `trip` is held rather than a bare OR. Finally, it walks the block flags across all variants: honouring a flag in the wrong variant shows up as a missing or spurious pickup.

// File: rtl/seqov_pkg.sv
package seqov_pkg;

    typedef enum logic [1:0] {
        VAR_POS  = 2'd0,
        VAR_NEG  = 2'd1,
        VAR_ZERO = 2'd2,
        VAR_RSVD = 2'd3
    } variant_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_TIMING  = 2'd1,
        ST_EXPIRED = 2'd2
    } stage_state_t;

    typedef enum logic {
        TR_CLEAR = 1'b0,
        TR_HELD  = 1'b1
    } trip_state_t;

endpackage

// File: rtl/seqov_release_level.sv
module seqov_release_level #(
    parameter int MAG_W   = 16,
    parameter int RATIO_W = 8
) (
    input  logic [MAG_W-1:0]   pickup,
    input  logic [RATIO_W-1:0] ratio,
    output logic [MAG_W-1:0]   level
);
    localparam int PROD_W = MAG_W + RATIO_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] shifted;

    always_comb begin
        prod    = {{RATIO_W{1'b0}}, pickup} * {{MAG_W{1'b0}}, ratio};
        shifted = prod >> RATIO_W;
        level   = shifted[MAG_W-1:0];
    end

endmodule

// File: rtl/seqov_block_sel.sv
module seqov_block_sel
    import seqov_pkg::*;
(
    input  logic [1:0] variant,
    input  logic       ext_blk,
    input  logic       volt_fail,
    input  logic       vt_trip,
    input  logic       dead_time,
    output logic       blk
);
    variant_t v;
    logic     asym_src;
    logic     dead_src;

    always_comb begin
        v        = variant_t'(variant);
        asym_src = 1'b0;
        dead_src = 1'b0;
        unique case (v)
            VAR_NEG: begin
                asym_src = volt_fail | vt_trip;
                dead_src = dead_time;
            end
            VAR_ZERO: begin
                asym_src = volt_fail | vt_trip;
            end
            VAR_POS, VAR_RSVD: begin
                asym_src = 1'b0;
            end
        endcase
        blk = ext_blk | asym_src | dead_src;
    end

endmodule

// File: rtl/seqov_stage.sv
module seqov_stage
    import seqov_pkg::*;
#(
    parameter int MAG_W   = 16,
    parameter int RATIO_W = 8,
    parameter int DLY_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               blk,
    input  logic [MAG_W-1:0]   mag,
    input  logic [MAG_W-1:0]   pickup,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [DLY_W-1:0]   delay,
    output logic               picked,
    output logic               expired
);
    stage_state_t     state_q, state_d;
    logic [DLY_W-1:0] cnt_q, cnt_d;
    logic [DLY_W-1:0] cnt_inc;
    logic [MAG_W-1:0] rel_lvl;
    logic             above_pu;
    logic             below_rel;

    seqov_release_level #(
        .MAG_W   (MAG_W),
        .RATIO_W (RATIO_W)
    ) u_rel (
        .pickup (pickup),
        .ratio  (ratio),
        .level  (rel_lvl)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next-state logic
    always_comb begin
        above_pu  = (mag >= pickup);
        below_rel = (mag < rel_lvl);
        cnt_inc   = cnt_q + 1'b1;
        state_d   = state_q;
        cnt_d     = cnt_q;
        if (blk) begin
            state_d = ST_IDLE;            // inhibit
            cnt_d   = '0;
        end else if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (above_pu) begin
                        cnt_d = '0;
                        if (delay == '0) state_d = ST_EXPIRED;  // arm-expire
                        else             state_d = ST_TIMING;   // arm
                    end
                end
                ST_TIMING: begin
                    if (below_rel) begin
                        state_d = ST_IDLE;                      // release
                        cnt_d   = '0;
                    end else if (cnt_inc >= delay) begin
                        state_d = ST_EXPIRED;                   // expire
                        cnt_d   = '0;
                    end else begin
                        cnt_d   = cnt_inc;
                    end
                end
                ST_EXPIRED: begin
                    if (below_rel) begin
                        state_d = ST_IDLE;                      // release
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        picked  = (state_q != ST_IDLE);
        expired = (state_q == ST_EXPIRED);
    end

endmodule

// File: rtl/seqov_trip.sv
module seqov_trip
    import seqov_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic blk,
    input  logic any_pu,
    input  logic any_to,
    output logic trip
);
    trip_state_t tstate_q, tstate_d;

    always_ff @(posedge clk) begin
        if (!rst_n) tstate_q <= TR_CLEAR;
        else        tstate_q <= tstate_d;
    end

    always_comb begin
        tstate_d = tstate_q;
        unique case (tstate_q)
            TR_CLEAR: if (any_to && !blk)       tstate_d = TR_HELD;   // latch
            TR_HELD:  if (blk || !any_pu)       tstate_d = TR_CLEAR;  // unlatch
            default:                            tstate_d = TR_CLEAR;
        endcase
    end

    always_comb begin
        trip = any_to || ((tstate_q == TR_HELD) && any_pu);
    end

endmodule

// File: rtl/seqov_guard.sv
module seqov_guard
    import seqov_pkg::*;
#(
    parameter int MAG_W   = 16,
    parameter int RATIO_W = 8,
    parameter int DLY_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [MAG_W-1:0]   mag,
    input  logic [1:0]         variant,
    input  logic               ext_blk,
    input  logic               volt_fail,
    input  logic               vt_trip,
    input  logic               dead_time,
    input  logic [MAG_W-1:0]   lo_pickup,
    input  logic [RATIO_W-1:0] lo_ratio,
    input  logic [DLY_W-1:0]   lo_delay,
    input  logic [MAG_W-1:0]   hi_pickup,
    input  logic [RATIO_W-1:0] hi_ratio,
    input  logic [DLY_W-1:0]   hi_delay,
    output logic               lo_pu,
    output logic               lo_to,
    output logic               hi_pu,
    output logic               hi_to,
    output logic               trip
);
    localparam int N_STAGES = 2;

    logic                          blk;
    logic [N_STAGES-1:0][MAG_W-1:0]   pu_set;
    logic [N_STAGES-1:0][RATIO_W-1:0] ratio_set;
    logic [N_STAGES-1:0][DLY_W-1:0]   dly_set;
    logic [N_STAGES-1:0]              pu_v;
    logic [N_STAGES-1:0]              to_v;

    seqov_block_sel u_blk (
        .variant   (variant),
        .ext_blk   (ext_blk),
        .volt_fail (volt_fail),
        .vt_trip   (vt_trip),
        .dead_time (dead_time),
        .blk       (blk)
    );

    always_comb begin
        pu_set[0]    = lo_pickup;
        pu_set[1]    = hi_pickup;
        ratio_set[0] = lo_ratio;
        ratio_set[1] = hi_ratio;
        dly_set[0]   = lo_delay;
        dly_set[1]   = hi_delay;
    end

    for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
        seqov_stage #(
            .MAG_W   (MAG_W),
            .RATIO_W (RATIO_W),
            .DLY_W   (DLY_W)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .blk     (blk),
            .mag     (mag),
            .pickup  (pu_set[s]),
            .ratio   (ratio_set[s]),
            .delay   (dly_set[s]),
            .picked  (pu_v[s]),
            .expired (to_v[s])
        );
    end

    seqov_trip u_trip (
        .clk    (clk),
        .rst_n  (rst_n),
        .blk    (blk),
        .any_pu (|pu_v),
        .any_to (|to_v),
        .trip   (trip)
    );

    always_comb begin
        lo_pu = pu_v[0];
        lo_to = to_v[0];
        hi_pu = pu_v[1];
        hi_to = to_v[1];
    end

endmodule

// File: rtl/seqov_guard_chk.sv
module seqov_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [1:0] variant,
    input logic       ext_blk,
    input logic       volt_fail,
    input logic       vt_trip,
    input logic       dead_time,
    input logic       lo_pu,
    input logic       lo_to,
    input logic       hi_pu,
    input logic       hi_to,
    input logic       trip
);
    a_r4_lo_to_needs_pu: assert property (@(posedge clk) disable iff (!rst_n)
        lo_to |-> lo_pu);
    a_r4_hi_to_needs_pu: assert property (@(posedge clk) disable iff (!rst_n)
        hi_to |-> hi_pu);
    a_r7_trip_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_to || hi_to) |-> trip);
    a_r7_trip_needs_pickup: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (lo_pu || hi_pu));
    a_r8_ext_block: assert property (@(posedge clk) disable iff (!rst_n)
        ext_blk |=> (!lo_pu && !hi_pu && !trip));
    a_r9_auto_block: assert property (@(posedge clk) disable iff (!rst_n)
        ((variant == 2'd1 || variant == 2'd2) && (volt_fail || vt_trip))
        |=> (!lo_pu && !hi_pu && !trip));
    a_r10_dead_block: assert property (@(posedge clk) disable iff (!rst_n)
        (variant == 2'd1 && dead_time) |=> (!lo_pu && !hi_pu));
    a_r2_pickup_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_pu) |-> $past(tick));
    a_r11_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ext_blk && !volt_fail && !vt_trip && !dead_time)
        |=> ($stable(lo_pu) && $stable(hi_pu) && $stable(lo_to) && $stable(hi_to)));
endmodule

bind seqov_guard seqov_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .variant   (variant),
    .ext_blk   (ext_blk),
    .volt_fail (volt_fail),
    .vt_trip   (vt_trip),
    .dead_time (dead_time),
    .lo_pu     (lo_pu),
    .lo_to     (lo_to),
    .hi_pu     (hi_pu),
    .hi_to     (hi_to),
    .trip      (trip)
);

// File: tb/seqov_guard_tb.sv
module seqov_guard_tb;
    localparam int MAG_W   = 16;
    localparam int RATIO_W = 8;
    localparam int DLY_W   = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tick = 1'b0;
    logic [MAG_W-1:0]   mag = '0;
    logic [1:0]         variant = 2'd0;
    logic               ext_blk = 1'b0, volt_fail = 1'b0, vt_trip = 1'b0, dead_time = 1'b0;
    logic [MAG_W-1:0]   lo_pickup = 16'd1000, hi_pickup = 16'd2000;
    logic [RATIO_W-1:0] lo_ratio = 8'd243, hi_ratio = 8'd230;
    logic [DLY_W-1:0]   lo_delay = 16'd3, hi_delay = 16'd1;
    logic               lo_pu, lo_to, hi_pu, hi_to, trip;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    seqov_guard #(.MAG_W(MAG_W), .RATIO_W(RATIO_W), .DLY_W(DLY_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mag(mag), .variant(variant),
        .ext_blk(ext_blk), .volt_fail(volt_fail), .vt_trip(vt_trip), .dead_time(dead_time),
        .lo_pickup(lo_pickup), .lo_ratio(lo_ratio), .lo_delay(lo_delay),
        .hi_pickup(hi_pickup), .hi_ratio(hi_ratio), .hi_delay(hi_delay),
        .lo_pu(lo_pu), .lo_to(lo_to), .hi_pu(hi_pu), .hi_to(hi_to), .trip(trip)
    );

    task automatic expect5(input string req, input logic [4:0] exp);
        logic [4:0] act;
        act = {lo_pu, lo_to, hi_pu, hi_to, trip};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {lo_pu,lo_to,hi_pu,hi_to,trip} actual %b expected %b", req, act, exp);
        end
    endtask

    // one strobe: inputs set at a falling edge, outputs sampled one falling edge later
    task automatic strobe(input logic [MAG_W-1:0] v);
        @(negedge clk);
        mag  = v;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic settle_idle();
        ext_blk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        ext_blk = 1'b0; volt_fail = 1'b0; vt_trip = 1'b0; dead_time = 1'b0;
        variant = 2'd0;
        lo_delay = 16'd3; hi_delay = 16'd1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect5("R1 in reset", 5'b00000);
        rst_n = 1'b1;
        @(negedge clk);
        expect5("R1 after reset", 5'b00000);
    endtask

    task automatic t_low_pickup_delay();
        strobe(16'd999);
        expect5("R2 one below pickup", 5'b00000);
        strobe(16'd1000);
        expect5("R2 low pickup", 5'b10000);
        strobe(16'd1000);
        strobe(16'd1000);
        expect5("R4 before delay", 5'b10000);
        strobe(16'd1000);
        expect5("R4 delay elapsed", 5'b11001);
        strobe(16'd949);
        expect5("R3 at release level holds", 5'b11001);
        strobe(16'd948);
        expect5("R3 below release drops", 5'b00000);
    endtask

    task automatic t_restart();
        strobe(16'd1000);
        strobe(16'd1000);
        strobe(16'd1000);
        strobe(16'd948);
        expect5("R5 release mid-delay", 5'b00000);
        strobe(16'd1000);
        strobe(16'd1000);
        strobe(16'd1000);
        expect5("R5 timer restarted", 5'b10000);
        strobe(16'd1000);
        expect5("R5 full delay", 5'b11001);
        settle_idle();
    endtask

    task automatic t_high_and_hold();
        lo_delay = 16'd10;
        strobe(16'd1999);
        expect5("R6 high one below", 5'b10000);
        strobe(16'd2000);
        expect5("R6 high pickup", 5'b10100);
        strobe(16'd1800);
        expect5("R6 high timeout", 5'b10111);
        strobe(16'd1796);
        expect5("R3 high release level holds", 5'b10111);
        strobe(16'd1795);
        expect5("R7 trip held by low stage", 5'b10001);
        repeat (3) @(negedge clk);
        expect5("R11 stable without strobe", 5'b10001);
        strobe(16'd900);
        expect5("R7 trip clears", 5'b00000);
        hi_delay = 16'd0;
        strobe(16'd2000);
        expect5("R4 zero delay", 5'b10111);
        settle_idle();
    endtask

    task automatic t_ext_block();
        variant = 2'd3;
        hi_delay = 16'd0;
        strobe(16'd3000);
        expect5("R8 pre-block pickup", 5'b10111);
        ext_blk = 1'b1;
        @(negedge clk);
        expect5("R8 block clears", 5'b00000);
        strobe(16'd3000);
        expect5("R8 no pickup while blocked", 5'b00000);
        ext_blk = 1'b0;
        strobe(16'd3000);
        expect5("R8 pickup after release", 5'b10111);
        settle_idle();
    endtask

    task automatic t_auto_block();
        variant = 2'd0; volt_fail = 1'b1; vt_trip = 1'b1;
        strobe(16'd1000);
        expect5("R9 positive ignores flags", 5'b10000);
        variant = 2'd1; vt_trip = 1'b0;
        @(negedge clk);
        expect5("R9 negative volt_fail blocks", 5'b00000);
        variant = 2'd2; volt_fail = 1'b0; vt_trip = 1'b1;
        strobe(16'd1000);
        expect5("R9 zero vt_trip blocks", 5'b00000);
        settle_idle();
    endtask

    task automatic t_dead_time();
        dead_time = 1'b1;
        variant = 2'd2;
        strobe(16'd1000);
        expect5("R10 zero ignores dead time", 5'b10000);
        variant = 2'd0;
        strobe(16'd1000);
        expect5("R10 positive ignores dead time", 5'b10000);
        variant = 2'd1;
        @(negedge clk);
        expect5("R10 negative dead time blocks", 5'b00000);
        strobe(16'd1000);
        expect5("R10 held off", 5'b00000);
        settle_idle();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        t_reset();
        t_low_pickup_delay();
        t_restart();
        t_high_and_hold();
        t_ext_block();
        t_auto_block();
        t_dead_time();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule